// File: doc/BRIEF.md
# Three-Channel Bidirectional Latching Buffer Controller

This block is the digital control model of a three-lane bidirectional buffer that sits between an A-side bus and a B-side bus. Each lane has its own direction input. When a lane points toward B, the B side carries the A-side level. When it points toward A, the A side carries the B-side level. For every lane the block produces data and an output-enable for each side, so the pads outside can be tri-stated.

Two shared enable inputs select one of four operating modes. In off mode nothing drives and the regulator flag is low. In regulator-only mode the flag is high and the buffer stays idle. In pass-through mode B-to-A lanes follow B without delay. In hold mode a B-to-A lane updates its A level only when the shared latch clock rises. The latch clock is sampled inside the system clock domain through a two-flop synchronizer, so the whole block runs on one clock.

Top module: `tri_lane_buffer_ctl`

## Requirements
- R1: With `en_main`=1 and a lane's `dir` bit=1, that lane drives `b_out`=`a_in` with `b_oe`=1 and `a_oe`=0. The latch clock does not change its outputs.
- R2: With `en_main`=1 and a lane's `dir` bit=0, that lane has `a_oe`=1 and `b_oe`=0.
- R3: Each lane follows its own `dir` bit (bit i controls lane i) without regard to the other lanes.
- R4: With `en_main`=0 and `en_aux`=0 (off), every `a_oe` and `b_oe` bit is 0, every data output is 0, and `reg_on` is 0.
- R5: With `en_main`=0 and `en_aux`=1 (regulator-only), `reg_on` is 1 and all enables and data outputs are 0.
- R6: With `en_main`=1 and `en_aux`=0 (pass-through), `reg_on` is 1 and a B-to-A lane shows `a_out`=`b_in` in the same cycle. Latch clock activity has no effect.
- R7: With `en_main`=1 and `en_aux`=1 (hold), a B-to-A lane loads the current `b_in` into `a_out` only on a rising latch clock. A falling latch clock leaves `a_out` unchanged.
- R8: The per-lane held value resets to 0 and keeps its value while the lane points toward B.
- R9: When the block enters hold mode, `a_out` keeps the last value driven in pass-through until the first rising latch clock.
- R10: Output-enables change in the same cycle as `dir`, `en_main` or `en_aux`, and no lane enables both sides at once. Data outputs are 0 whenever their enable is 0.
- R11: A latch clock high first sampled at clock edge k becomes visible on `a_out` after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_main | input | 1 | First mode enable |
| en_aux | input | 1 | Second mode enable |
| dir | input | 3 | Per-lane direction, 1 = A to B |
| latch_clk | input | 1 | Asynchronous latch clock |
| a_in | input | 3 | A-side pad levels |
| b_in | input | 3 | B-side pad levels |
| a_out | output | 3 | A-side drive data |
| a_oe | output | 3 | A-side output-enable |
| b_out | output | 3 | B-side drive data |
| b_oe | output | 3 | B-side output-enable |
| reg_on | output | 1 | Regulator-enable flag |

## Verification
The only state in the block is each lane's held A value and the synchronizer chain. A corrupt held value shows up on `a_out` as soon as that lane drives A in hold mode. It also shows up on entry to hold mode, before any latch clock edge. A fault in the synchronizer shows up as a capture one edge early or late, or as a capture on the falling edge of the latch clock. The bench therefore checks `a_out` after each of the three edges that follow a latch clock change. The output-enable logic has no state, so a fault there shows in the same cycle as the input pattern that reaches it. The bench covers this with a full sweep of modes, directions and data.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_REG  = 2'b01,
    MODE_PASS = 2'b10,
    MODE_HOLD = 2'b11
  } tlb_mode_e;

  function automatic tlb_mode_e mode_decode(input logic en_main, input logic en_aux);
    return tlb_mode_e'({en_main, en_aux});
  endfunction

  function automatic logic mode_links(input tlb_mode_e m);
    return (m == MODE_PASS) || (m == MODE_HOLD);
  endfunction

  function automatic logic mode_powered(input tlb_mode_e m);
    return m != MODE_OFF;
  endfunction

  // next held value of one lane
  function automatic logic hold_next(input tlb_mode_e m, input logic to_b,
                                     input logic rise, input logic b_lvl,
                                     input logic cur);
    if (to_b)                          return cur;
    else if (m == MODE_PASS)           return b_lvl;
    else if (m == MODE_HOLD && rise)   return b_lvl;
    else                               return cur;
  endfunction

endpackage

// File: rtl/tlb_edge_sync.sv
module tlb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_i;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its delayed copy
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tlb_lane.sv
module tlb_lane
  import tlb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tlb_mode_e mode,
  input  logic      to_b,
  input  logic      rise,
  input  logic      a_lvl,
  input  logic      b_lvl,
  output logic      a_drv,
  output logic      a_en,
  output logic      b_drv,
  output logic      b_en
);

  logic hold_q;
  logic links;

  assign links = mode_links(mode);
  assign b_en  = links & to_b;
  assign a_en  = links & ~to_b;
  assign b_drv = b_en & a_lvl;
  assign a_drv = a_en & ((mode == MODE_HOLD) ? hold_q : b_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_next(mode, to_b, rise, b_lvl, hold_q);
  end

  a_r8_hold_while_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    to_b |=> $stable(hold_q));

  a_r7_no_capture_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !rise) |=> $stable(hold_q));

  a_r7_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && rise && !to_b) |=> hold_q == $past(b_lvl));

  a_r6_pass_follows_b: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PASS && !to_b) |-> a_drv == b_lvl);

  a_r1_b_from_a: assert property (@(posedge clk) disable iff (!rst_n)
    (links && to_b) |-> (b_drv == a_lvl && !a_drv));

endmodule

// File: rtl/tri_lane_buffer_ctl.sv
module tri_lane_buffer_ctl
  import tlb_pkg::*;
#(
  parameter int LANES       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_main,
  input  logic             en_aux,
  input  logic [LANES-1:0] dir,
  input  logic             latch_clk,
  input  logic [LANES-1:0] a_in,
  input  logic [LANES-1:0] b_in,
  output logic [LANES-1:0] a_out,
  output logic [LANES-1:0] a_oe,
  output logic [LANES-1:0] b_out,
  output logic [LANES-1:0] b_oe,
  output logic             reg_on
);

  tlb_mode_e mode;
  logic      latch_rise;

  assign mode   = mode_decode(en_main, en_aux);
  assign reg_on = mode_powered(mode);

  tlb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (latch_clk),
    .rise_o  (latch_rise)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tlb_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .to_b  (dir[i]),
      .rise  (latch_rise),
      .a_lvl (a_in[i]),
      .b_lvl (b_in[i]),
      .a_drv (a_out[i]),
      .a_en  (a_oe[i]),
      .b_drv (b_out[i]),
      .b_en  (b_oe[i])
    );
  end

  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_main && !en_aux) |-> (a_oe == '0 && b_oe == '0 && !reg_on));

  a_r5_reg_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_main && en_aux) |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0 && reg_on));

  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe & b_oe) == '0);

  a_r3_lane_split: assert property (@(posedge clk) disable iff (!rst_n)
    en_main |-> (b_oe == dir && a_oe == ~dir));

endmodule

// File: tb/tri_lane_buffer_ctl_bench.sv
module tri_lane_buffer_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_main = 1'b0, en_aux = 1'b0, latch_clk = 1'b0;
  logic [2:0] dir = '0, a_in = '0, b_in = '0;
  logic [2:0] a_out, a_oe, b_out, b_oe;
  logic       reg_on;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_lane_buffer_ctl u_tri_lane_buffer_ctl (
    .clk(clk), .rst_n(rst_n), .en_main(en_main), .en_aux(en_aux), .dir(dir),
    .latch_clk(latch_clk), .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe), .reg_on(reg_on));

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [12:0] pack_out();
    return {reg_on, a_out, a_oe, b_out, b_oe};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    done = 1;
  end

  initial begin
    step(2);
    chk("R4 reset", pack_out(), 13'b0);
    rst_n = 1'b1;
    step(1);
    // R8: held value is 0 after reset
    en_main = 1; en_aux = 1; dir = 3'b000; b_in = 3'b111;
    #1 chk("R8 reset hold", {10'b0, a_out}, {10'b0, 3'b000});
    step(1);

    // R1 R2 R3 R4 R5 R6 R10: sweep of modes, directions and data
    for (int m = 0; m < 3; m++)
      for (int d = 0; d < 8; d++)
        for (int a = 0; a < 8; a++)
          for (int b = 0; b < 8; b++) begin
            logic act; logic [2:0] eb, ea;
            en_main = m[1]; en_aux = m[0];
            dir = d[2:0]; a_in = a[2:0]; b_in = b[2:0];
            latch_clk = a[0] ^ b[1];
            act = (m == 2);
            eb = act ? d[2:0] : 3'b000;
            ea = act ? ~d[2:0] : 3'b000;
            #1 chk(m == 0 ? "R4 sweep" : (m == 1 ? "R5 sweep" : "R6 R1 R2 R3 R10 sweep"),
                   pack_out(), {(m != 0), b[2:0] & ea, ea, a[2:0] & eb, eb});
            step(1);
          end

    // R9: last pass-through value survives entry to hold mode
    en_main = 1; en_aux = 0; dir = 3'b000; b_in = 3'b101; latch_clk = 0;
    step(4);
    en_aux = 1; b_in = 3'b010;
    #1 chk("R9 entry keeps value", {10'b0, a_out}, {10'b0, 3'b101});
    step(1);
    // R7 R11: rise seen after third edge
    latch_clk = 1;
    step(1); chk("R11 edge1 unchanged", {10'b0, a_out}, {10'b0, 3'b101});
    step(1); chk("R11 edge2 unchanged", {10'b0, a_out}, {10'b0, 3'b101});
    step(1); chk("R7 R11 edge3 captured", {10'b0, a_out}, {10'b0, 3'b010});
    // R7: falling edge has no effect
    b_in = 3'b111; latch_clk = 0;
    step(4); chk("R7 falling ignored", {10'b0, a_out}, {10'b0, 3'b010});
    // R10 R3 R1: lane 0 turns to B within the same cycle
    dir = 3'b001; a_in = 3'b001;
    #1 chk("R10 R3 same-cycle turn", pack_out(), {1'b1, 3'b010, 3'b110, 3'b001, 3'b001});
    step(1);
    latch_clk = 1; step(3);
    chk("R1 R7 lane0 ignores clock", pack_out(), {1'b1, 3'b110, 3'b110, 3'b001, 3'b001});
    latch_clk = 0; step(3);
    dir = 3'b000;
    #1 chk("R8 held while to B", {10'b0, a_out}, {10'b0, 3'b110});
    step(1);
    en_aux = 0;
    #1 chk("R6 back to pass", {10'b0, a_out}, {10'b0, 3'b111});
    done = 1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule